// File: doc/BRIEF.md
# Banked MMU Address Translator

This block sits between a 16-bit processor's 20-bit address bus and the memory system. It converts every CPU address into a target class and a physical offset. The target is RAM, ROM, a peripheral slot, the mainboard register slot, the CPU register page or nothing. The address space is cut into 256 banks of 4 KB. Each bank points at an 8-bit area number held in a table, and the area number picks both the target and the physical position inside it.

The table is reachable from software only through the mainboard slot of the peripheral window. One register selects which bank is being configured. A second register reads or writes the area that this bank points to. The mainboard slot also returns a fixed vendor code and a capability word. The top 128 bytes of the address space always reach the CPU register page, whatever the table holds. The translation is purely combinational from the address and the table. A register write takes effect at the clock edge that captures it.

Top module: `mmu_xlate`

## Requirements
- R1: After reset, banks $00-$EF map to RAM at the same address and banks $FE/$FF map to ROM with physical offsets $00000-$01FFF, with `sel_o` codes 0=none, 1=RAM, 2=ROM, 3=I/O, 4=CPU register page, 5=mainboard.
- R2: After reset, banks $F0-$FB map to RAM at physical bank (bank - $F0), so $F5ABC reaches RAM $05ABC.
- R3: After reset, bank $FC selects class 0 (none), with `phys_o` = 0 and `rdata_o` = $FF.
- R4: After reset, bank $FD selects I/O. Slots 0-14 (address bits 11..8) give class 3 and `phys_o` = address bits 11..0.
- R5: Any access that decodes to I/O with slot 15 selects class 5 (mainboard), and `phys_o` = address bits 11..0. This holds for every bank whose area is 242. It does not hold for bank $FD once $FD is remapped.
- R6: Mainboard offsets $04-$07 return the capability word (default $00000001) least significant byte first, and writes there have no effect.
- R7: Mainboard offsets $00/$01 return the vendor code (default $8001) low byte first. Every other unassigned offset reads $00.
- R8: Mainboard offset $08 is a read/write bank index that is $00 after reset. A write to offset $09 loads the table entry of the indexed bank from `wdata_i`, and a read of $09 returns that entry. Both writes take effect at the capturing clock edge.
- R9: Area values decode as follows: 0-239 give RAM with `phys_o` = {area, addr[11:0]}; 240-241 give ROM with `phys_o` = {area-240, addr[11:0]}; 242 gives I/O; 243-255 give class 0.
- R10: Addresses $FFF80-$FFFFF give class 4 with `phys_o` = address bits 6..0, whatever the table holds for bank $FF.
- R11: Writes that do not decode to mainboard offsets $08/$09 leave the index and the table unchanged. This includes writes to class-0 addresses.
- R12: `rdata_o` is $00 for the RAM, ROM, I/O and CPU register classes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 20 | CPU address |
| wr_i | input | 1 | Write strobe for the current address |
| wdata_i | input | 8 | Write data byte |
| sel_o | output | 3 | Target class of the address |
| phys_o | output | 20 | Translated offset within the target |
| rdata_o | output | 8 | Mainboard register read data, $FF for class none |

## Verification
On every cycle, the assertions check several properties: the CPU register page overrides the table, a class-none access returns $FF with a zero offset, and RAM hits keep the in-bank offset below the RAM area limit. They also check that the quiet classes return zero data, that the mainboard class only appears in slot 15, and that the bank index changes exactly when its offset is written. The reset contents of the table need the bench's scenarios to show them. So do the area decode after reprogramming, the mainboard appearing in a remapped bank and vanishing from $FD, the read-only capability bytes, and the restoring of the map by a second reset.

// File: rtl/mmu_pkg.sv
package mmu_pkg;
  localparam int ADDR_W = 20;
  localparam int BANK_W = 8;
  localparam int AREA_W = 8;
  localparam int OFF_W  = ADDR_W - BANK_W;
  localparam int BANKS  = 2 ** BANK_W;

  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_RAM  = 3'd1,
    SEL_ROM  = 3'd2,
    SEL_IO   = 3'd3,
    SEL_CREG = 3'd4,
    SEL_MB   = 3'd5
  } sel_e;

  // power-on bank map
  function automatic logic [AREA_W-1:0] reset_area(input logic [BANK_W-1:0] b);
    logic [AREA_W-1:0] a;
    if (b < 8'hF0)       a = b;
    else if (b <= 8'hFB) a = b - 8'hF0;
    else if (b == 8'hFD) a = 8'd242;
    else if (b == 8'hFE) a = 8'd240;
    else if (b == 8'hFF) a = 8'd241;
    else                 a = 8'hFF;
    return a;
  endfunction
endpackage

// File: rtl/mmu_bank_table.sv
module mmu_bank_table
  import mmu_pkg::*;
#(
  parameter int BW = BANK_W,
  parameter int AW = AREA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          idx_we_i,
  input  logic          dat_we_i,
  input  logic [7:0]    wdata_i,
  input  logic [BW-1:0] look_bank_i,
  output logic [AW-1:0] look_area_o,
  output logic [BW-1:0] idx_o,
  output logic [AW-1:0] cur_area_o
);
  localparam int N = 2 ** BW;

  logic [AW-1:0] tbl_q [N];
  logic [BW-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      for (int i = 0; i < N; i++) tbl_q[i] <= reset_area(BW'(i));
    end else begin
      if (idx_we_i) idx_q <= wdata_i[BW-1:0];
      if (dat_we_i) tbl_q[idx_q] <= wdata_i[AW-1:0];
    end
  end

  assign look_area_o = tbl_q[look_bank_i];
  assign cur_area_o  = tbl_q[idx_q];
  assign idx_o       = idx_q;
endmodule

// File: rtl/mmu_area_decode.sv
module mmu_area_decode
  import mmu_pkg::*;
#(
  parameter int RAM_AREAS = 240,
  parameter int ROM_BASE  = 240,
  parameter int ROM_AREAS = 2,
  parameter int IO_AREA   = 242,
  parameter int MB_SLOT   = 15,
  parameter int CREG_W    = 7
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [AREA_W-1:0] area_i,
  output sel_e              sel_o,
  output logic [ADDR_W-1:0] phys_o
);
  localparam logic [AREA_W-1:0] RAM_LIM = AREA_W'(RAM_AREAS);
  localparam logic [AREA_W-1:0] ROM_LO  = AREA_W'(ROM_BASE);
  localparam logic [AREA_W-1:0] ROM_HI  = AREA_W'(ROM_BASE + ROM_AREAS);
  localparam logic [AREA_W-1:0] IO_VAL  = AREA_W'(IO_AREA);
  localparam int SLOT_W = 4;

  logic [OFF_W-1:0]  off;
  logic [SLOT_W-1:0] slot;
  logic [AREA_W-1:0] rom_idx;
  logic              creg_hit;

  assign off      = addr_i[OFF_W-1:0];
  assign slot     = off[OFF_W-1 -: SLOT_W];
  assign rom_idx  = area_i - ROM_LO;
  assign creg_hit = &addr_i[ADDR_W-1:CREG_W];

  always_comb begin
    sel_o  = SEL_NONE;
    phys_o = '0;
    if (creg_hit) begin
      sel_o  = SEL_CREG;
      phys_o = ADDR_W'(addr_i[CREG_W-1:0]);
    end else if (area_i < RAM_LIM) begin
      sel_o  = SEL_RAM;
      phys_o = {area_i, off};
    end else if (area_i >= ROM_LO && area_i < ROM_HI) begin
      sel_o  = SEL_ROM;
      phys_o = {rom_idx, off};
    end else if (area_i == IO_VAL) begin
      sel_o  = (slot == SLOT_W'(MB_SLOT)) ? SEL_MB : SEL_IO;
      phys_o = ADDR_W'(off);
    end
  end
endmodule

// File: rtl/mmu_mb_regs.sv
module mmu_mb_regs
  import mmu_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID = 16'h8001,
  parameter logic [31:0] CAP_WORD  = 32'h0000_0001
) (
  input  logic              mb_sel_i,
  input  logic              wr_i,
  input  logic [7:0]        ofs_i,
  input  logic [BANK_W-1:0] idx_i,
  input  logic [AREA_W-1:0] cur_area_i,
  output logic              idx_we_o,
  output logic              dat_we_o,
  output logic [7:0]        rdata_o
);
  localparam logic [7:0] OFS_VID0 = 8'h00;
  localparam logic [7:0] OFS_VID1 = 8'h01;
  localparam logic [7:0] OFS_CAP0 = 8'h04;
  localparam logic [7:0] OFS_CAP1 = 8'h05;
  localparam logic [7:0] OFS_CAP2 = 8'h06;
  localparam logic [7:0] OFS_CAP3 = 8'h07;
  localparam logic [7:0] OFS_IDX  = 8'h08;
  localparam logic [7:0] OFS_AREA = 8'h09;

  assign idx_we_o = mb_sel_i && wr_i && (ofs_i == OFS_IDX);
  assign dat_we_o = mb_sel_i && wr_i && (ofs_i == OFS_AREA);

  always_comb begin
    unique case (ofs_i)
      OFS_VID0: rdata_o = VENDOR_ID[7:0];
      OFS_VID1: rdata_o = VENDOR_ID[15:8];
      OFS_CAP0: rdata_o = CAP_WORD[7:0];
      OFS_CAP1: rdata_o = CAP_WORD[15:8];
      OFS_CAP2: rdata_o = CAP_WORD[23:16];
      OFS_CAP3: rdata_o = CAP_WORD[31:24];
      OFS_IDX:  rdata_o = 8'(idx_i);
      OFS_AREA: rdata_o = 8'(cur_area_i);
      default:  rdata_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/mmu_xlate.sv
module mmu_xlate
  import mmu_pkg::*;
#(
  parameter int          RAM_AREAS = 240,
  parameter int          ROM_BASE  = 240,
  parameter int          ROM_AREAS = 2,
  parameter int          IO_AREA   = 242,
  parameter int          MB_SLOT   = 15,
  parameter int          CREG_W    = 7,
  parameter logic [15:0] VENDOR_ID = 16'h8001,
  parameter logic [31:0] CAP_WORD  = 32'h0000_0001
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [7:0]        wdata_i,
  output logic [2:0]        sel_o,
  output logic [ADDR_W-1:0] phys_o,
  output logic [7:0]        rdata_o
);
  logic [AREA_W-1:0] look_area;
  logic [AREA_W-1:0] cur_area;
  logic [BANK_W-1:0] idx_q;
  logic              idx_we, dat_we;
  logic [7:0]        mb_rdata;
  sel_e              sel;

  mmu_bank_table #(.BW(BANK_W), .AW(AREA_W)) u_table (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .idx_we_i    (idx_we),
    .dat_we_i    (dat_we),
    .wdata_i     (wdata_i),
    .look_bank_i (addr_i[ADDR_W-1:OFF_W]),
    .look_area_o (look_area),
    .idx_o       (idx_q),
    .cur_area_o  (cur_area)
  );

  mmu_area_decode #(
    .RAM_AREAS (RAM_AREAS),
    .ROM_BASE  (ROM_BASE),
    .ROM_AREAS (ROM_AREAS),
    .IO_AREA   (IO_AREA),
    .MB_SLOT   (MB_SLOT),
    .CREG_W    (CREG_W)
  ) u_decode (
    .addr_i (addr_i),
    .area_i (look_area),
    .sel_o  (sel),
    .phys_o (phys_o)
  );

  mmu_mb_regs #(.VENDOR_ID(VENDOR_ID), .CAP_WORD(CAP_WORD)) u_mb (
    .mb_sel_i   (sel == SEL_MB),
    .wr_i       (wr_i),
    .ofs_i      (addr_i[7:0]),
    .idx_i      (idx_q),
    .cur_area_i (cur_area),
    .idx_we_o   (idx_we),
    .dat_we_o   (dat_we),
    .rdata_o    (mb_rdata)
  );

  assign sel_o   = sel;
  assign rdata_o = (sel == SEL_MB)   ? mb_rdata :
                   (sel == SEL_NONE) ? 8'hFF : 8'h00;
endmodule

// File: rtl/mmu_xlate_chk.sv
module mmu_xlate_chk
  import mmu_pkg::*;
#(
  parameter int RAM_AREAS = 240,
  parameter int CREG_W    = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_i,
  input logic [7:0]        wdata_i,
  input logic [2:0]        sel_o,
  input logic [ADDR_W-1:0] phys_o,
  input logic [7:0]        rdata_o,
  input logic [BANK_W-1:0] idx_q
);
  logic idx_wr;
  assign idx_wr = wr_i && (sel_o == 3'(SEL_MB)) && (addr_i[7:0] == 8'h08);

  p_creg_page_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&addr_i[ADDR_W-1:CREG_W]) |-> (sel_o == 3'(SEL_CREG)) &&
                                   (phys_o == ADDR_W'(addr_i[CREG_W-1:0])));

  p_none_reads_ff_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o == 3'(SEL_NONE)) |-> (rdata_o == 8'hFF) && (phys_o == '0));

  p_ram_offset_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o == 3'(SEL_RAM)) |-> (phys_o[OFF_W-1:0] == addr_i[OFF_W-1:0]) &&
                               (phys_o[ADDR_W-1:OFF_W] < AREA_W'(RAM_AREAS)));

  p_quiet_rdata_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o inside {3'(SEL_RAM), 3'(SEL_ROM), 3'(SEL_IO), 3'(SEL_CREG)}) |-> (rdata_o == 8'h00));

  p_mb_slot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o == 3'(SEL_MB)) |-> (addr_i[OFF_W-1 -: 4] == 4'hF));

  p_idx_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_wr |=> (idx_q == $past(wdata_i)));

  p_idx_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idx_wr |=> $stable(idx_q));

  p_sel_legal_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_o <= 3'(SEL_MB));
endmodule

bind mmu_xlate mmu_xlate_chk #(.RAM_AREAS(RAM_AREAS), .CREG_W(CREG_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .wr_i    (wr_i),
  .wdata_i (wdata_i),
  .sel_o   (sel_o),
  .phys_o  (phys_o),
  .rdata_o (rdata_o),
  .idx_q   (idx_q)
);

// File: tb/tb_mmu_xlate.sv
module tb_mmu_xlate;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [19:0] addr_i;
  logic        wr_i;
  logic [7:0]  wdata_i;
  logic [2:0]  sel_o;
  logic [19:0] phys_o;
  logic [7:0]  rdata_o;

  int checks = 0;
  int errors = 0;

  // sel codes
  localparam logic [2:0] NONE = 3'd0, RAM = 3'd1, ROM = 3'd2, IO = 3'd3, CREG = 3'd4, MB = 3'd5;

  mmu_xlate dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i),
    .wdata_i(wdata_i), .sel_o(sel_o), .phys_o(phys_o), .rdata_o(rdata_o)
  );

  always #4 clk_i = ~clk_i;

  // {req, addr, sel, phys, rdata}
  localparam int NV = 18;
  localparam logic [54:0] VEC [NV] = '{
    {4'd1,  20'h12345, RAM,  20'h12345, 8'h00},  // R1
    {4'd1,  20'hEFFFF, RAM,  20'hEFFFF, 8'h00},  // R1
    {4'd2,  20'hF5ABC, RAM,  20'h05ABC, 8'h00},  // R2
    {4'd2,  20'hFB001, RAM,  20'h0B001, 8'h00},  // R2
    {4'd3,  20'hFC123, NONE, 20'h00000, 8'hFF},  // R3
    {4'd4,  20'hFD305, IO,   20'h00305, 8'h00},  // R4
    {4'd4,  20'hFDE10, IO,   20'h00E10, 8'h00},  // R4
    {4'd6,  20'hFDF04, MB,   20'h00F04, 8'h01},  // R6
    {4'd6,  20'hFDF05, MB,   20'h00F05, 8'h00},  // R6
    {4'd7,  20'hFDF00, MB,   20'h00F00, 8'h01},  // R7
    {4'd7,  20'hFDF01, MB,   20'h00F01, 8'h80},  // R7
    {4'd7,  20'hFDF02, MB,   20'h00F02, 8'h00},  // R7
    {4'd8,  20'hFDF09, MB,   20'h00F09, 8'h00},  // R8
    {4'd1,  20'hFE010, ROM,  20'h00010, 8'h00},  // R1
    {4'd1,  20'hFFF7F, ROM,  20'h01F7F, 8'h00},  // R1
    {4'd10, 20'hFFF80, CREG, 20'h00000, 8'h00},  // R10
    {4'd10, 20'hFFFFF, CREG, 20'h0007F, 8'h00},  // R10
    {4'd7,  20'hFDFFF, MB,   20'h00FFF, 8'h00}   // R7
  };

  task automatic chk(input string req, input string what, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic probe(input string req, input logic [19:0] a, input logic [2:0] s,
                       input logic [19:0] p, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a;
    #1;
    chk(req, "sel", 20'(sel_o), 20'(s));
    chk(req, "phys", phys_o, p);
    chk(req, "rdata", 20'(rdata_o), 20'(d));
  endtask

  task automatic wr(input logic [19:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(posedge clk_i);
    #1 wr_i = 1'b0;
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 20000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_ni = 1'b0; addr_i = '0; wr_i = 1'b0; wdata_i = '0;
    repeat (3) @(posedge clk_i);
    probe("R1", 20'h00000, RAM, 20'h00000, 8'h00);  // reset state
    @(negedge clk_i) rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      addr_i = VEC[i][50:31];
      #1;
      chk($sformatf("R%0d", VEC[i][54:51]), "sel", 20'(sel_o), 20'(VEC[i][30:28]));
      chk($sformatf("R%0d", VEC[i][54:51]), "phys", phys_o, VEC[i][27:8]);
      chk($sformatf("R%0d", VEC[i][54:51]), "rdata", 20'(rdata_o), 20'(VEC[i][7:0]));
    end

    // R8 index and entry access
    wr(20'hFDF08, 8'h23);
    probe("R8", 20'hFDF08, MB, 20'h00F08, 8'h23);
    wr(20'hFDF09, 8'hF1);
    probe("R8", 20'hFDF09, MB, 20'h00F09, 8'hF1);
    // R9 area decode
    probe("R9", 20'h23456, ROM, 20'h01456, 8'h00);
    wr(20'hFDF09, 8'hF2);
    probe("R9", 20'h23456, IO, 20'h00456, 8'h00);
    probe("R5", 20'h23F08, MB, 20'h00F08, 8'h23);
    wr(20'hFDF09, 8'hF3);
    probe("R9", 20'h23456, NONE, 20'h00000, 8'hFF);
    wr(20'hFDF09, 8'h77);
    probe("R9", 20'h23456, RAM, 20'h77456, 8'h00);

    // R6 capability is read-only
    wr(20'hFDF04, 8'hAA);
    probe("R6", 20'hFDF04, MB, 20'h00F04, 8'h01);
    // R11 stray writes change nothing
    wr(20'hFC008, 8'h55);
    probe("R11", 20'hFDF08, MB, 20'h00F08, 8'h23);
    wr(20'hFC009, 8'h00);
    wr(20'h00009, 8'h00);
    probe("R11", 20'hFDF09, MB, 20'h00F09, 8'h77);
    probe("R11", 20'h23456, RAM, 20'h77456, 8'h00);

    // R10 register page overrides table
    wr(20'hFDF08, 8'hFF);
    wr(20'hFDF09, 8'h00);
    probe("R10", 20'hFFF80, CREG, 20'h00000, 8'h00);
    probe("R10", 20'hFFFC3, CREG, 20'h00043, 8'h00);
    probe("R10", 20'hFFF7F, RAM, 20'h00F7F, 8'h00);

    // R5 mainboard follows area 242, leaves remapped $FD
    wr(20'hFDF08, 8'h23);
    wr(20'hFDF09, 8'hF2);
    wr(20'hFDF08, 8'hFD);
    wr(20'hFDF09, 8'h05);
    probe("R5", 20'hFDF08, RAM, 20'h05F08, 8'h00);
    wr(20'h23F09, 8'hF2);
    probe("R5", 20'hFDF08, MB, 20'h00F08, 8'hFD);

    // second reset restores map
    @(negedge clk_i) rst_ni = 1'b0;
    probe("R1", 20'h23456, RAM, 20'h23456, 8'h00);
    probe("R8", 20'hFDF08, MB, 20'h00F08, 8'h00);
    probe("R1", 20'hFFF00, ROM, 20'h01F00, 8'h00);
    @(negedge clk_i) rst_ni = 1'b1;
    probe("R12", 20'hFD000, IO, 20'h00000, 8'h00);

    summary();
  end
endmodule